// File: doc/BRIEF.md
# Boot-Remap Memory Address Decoder

This block sits on the bus side of a small microcontroller and sorts every access to its internal address space into one of three on-chip memories (Flash, SRAM, ROM) or into an abort. The space is cut into 1 MB regions. Region 1 always reaches Flash, region 2 SRAM and region 3 ROM, and every region from 4 up to the top of the 256 MB internal space is undefined. Region 0 is a moving alias. Its target depends on a boot-select bit and on a one-shot remap command.

Before remap, region 0 shows ROM when the boot bit is 0 and Flash when the boot bit is 1. After the remap command has been taken, region 0 shows SRAM from then on. This allows startup code to run from non-volatile memory and then place writable memory at the vector area.

The remap flag is cleared by any reset. The boot bit is a separate register. It takes no notice of the soft reset and is cleared only by power-on reset, by the clear command or by the erase input. Memory sizes are parameters. An offset that goes past a memory's size wraps round inside that memory. A 512 KB Flash is built from two 256 KB planes, and the decoder gives a plane-select output for it.

Top module: `boot_remap_decoder`

## Requirements
- R1: With accValid high, region 1 (addr[27:20]==1) asserts only csFlash, region 2 only csSram and region 3 only csRom.
- R2: Before remap, a valid access to region 0 asserts csRom when the boot bit is 0 and csFlash when it is 1.
- R3: A cycle with cmdRemap high at a clock edge makes region 0 assert csSram from the next cycle on, whatever the boot bit is. The flag stays set until a reset.
- R4: A valid access to any region from 4 to 255 asserts abort and no chip select.
- R5: localOffset is addr[19:0] modulo the size of the selected memory (SRAM_KB, FLASH_KB, ROM_KB, each in KB). It is 0 on an abort.
- R6: When FLASH_KB is 512, flashPlane equals localOffset[18] while csFlash is high. At all other times flashPlane is 0.
- R7: cmdSetBoot sets the boot bit and cmdClearBoot clears it, both from the next cycle. If both are high together, clear wins.
- R8: eraseIn high at a clock edge clears the boot bit, whatever else is asserted with it.
- R9: softRst_n low clears the remap flag and leaves the boot bit unchanged. porRst_n low clears both.
- R10: With accValid low, all chip selects, abort, flashPlane and localOffset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst_n | input | 1 | Power-on reset, active low; clears boot bit and remap flag |
| softRst_n | input | 1 | Soft reset, active low; clears remap flag only |
| accValid | input | 1 | An access is present on accAddr |
| accAddr | input | 28 | Byte address in the internal space |
| cmdRemap | input | 1 | One-shot remap command |
| cmdSetBoot | input | 1 | Set the boot-select bit (boot from Flash) |
| cmdClearBoot | input | 1 | Clear the boot-select bit (boot from ROM) |
| eraseIn | input | 1 | Erase; clears the boot-select bit |
| csFlash | output | 1 | Flash chip select |
| csSram | output | 1 | SRAM chip select |
| csRom | output | 1 | ROM chip select |
| abort | output | 1 | Access to undefined space |
| localOffset | output | 20 | Byte offset inside the selected memory |
| flashPlane | output | 1 | Flash plane select for the dual-plane size |

## Verification
The assertions check on every cycle that at most one of the four outcomes is raised, and exactly one when an access is present. They also check that undefined regions abort, that the remap flag never falls without a reset, that region 0 goes to SRAM once remapped, that erase always clears the boot bit, and that the plane output stays low away from Flash. Only the bench scenarios can show the full picture. These cover the wrap of offsets at each memory's size, the ROM-or-Flash choice before remap, the order of priority when set and clear come together, and that a soft reset keeps the boot bit while dropping the remap.

// File: rtl/brd_pkg.sv
package brd_pkg;

  // Strobes the control side hands to the datapath
  typedef struct packed {
    logic remapped;   // region 0 shows SRAM
    logic bootFlash;  // boot-select bit: 1 = Flash, 0 = ROM
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    TGT_FLASH = 2'd0,
    TGT_SRAM  = 2'd1,
    TGT_ROM   = 2'd2,
    TGT_ABORT = 2'd3
  } target_e;

endpackage

// File: rtl/brd_ctrl.sv
module brd_ctrl
  import brd_pkg::*;
(
  input  logic         clk,
  input  logic         porRst_n,
  input  logic         softRst_n,
  input  logic         cmdRemap,
  input  logic         cmdSetBoot,
  input  logic         cmdClearBoot,
  input  logic         eraseIn,
  output ctrl_strobe_t strobe
);

  logic bootBit;
  logic remapFlag;
  logic remapRst_n;

  // Remap is dropped by either reset; the boot bit only by power-on
  assign remapRst_n = porRst_n & softRst_n;

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      bootBit <= 1'b0;
    end else if (eraseIn || cmdClearBoot) begin
      bootBit <= 1'b0;
    end else if (cmdSetBoot) begin
      bootBit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge remapRst_n) begin
    if (!remapRst_n) begin
      remapFlag <= 1'b0;
    end else if (cmdRemap) begin
      remapFlag <= 1'b1;
    end
  end

  assign strobe.remapped  = remapFlag;
  assign strobe.bootFlash = bootBit;

endmodule

// File: rtl/brd_datapath.sv
module brd_datapath
  import brd_pkg::*;
#(
  parameter int ADDR_W      = 28,
  parameter int REGION_BITS = 20,
  parameter int SRAM_KB     = 128,
  parameter int FLASH_KB    = 512,
  parameter int ROM_KB      = 32
) (
  input  logic                   accValid,
  input  logic [ADDR_W-1:0]      accAddr,
  input  ctrl_strobe_t           strobe,
  output logic                   csFlash,
  output logic                   csSram,
  output logic                   csRom,
  output logic                   abort,
  output logic [REGION_BITS-1:0] localOffset,
  output logic                   flashPlane
);

  localparam int REGION_W = ADDR_W - REGION_BITS;
  localparam logic [REGION_BITS-1:0] SRAM_MASK  = REGION_BITS'(SRAM_KB * 1024 - 1);
  localparam logic [REGION_BITS-1:0] FLASH_MASK = REGION_BITS'(FLASH_KB * 1024 - 1);
  localparam logic [REGION_BITS-1:0] ROM_MASK   = REGION_BITS'(ROM_KB * 1024 - 1);
  localparam int PLANE_BIT = 18;

  logic [REGION_W-1:0]    region;
  logic [REGION_BITS-1:0] rawOff;
  logic [REGION_BITS-1:0] offMask;
  target_e                target;

  assign region = accAddr[ADDR_W-1:REGION_BITS];
  assign rawOff = accAddr[REGION_BITS-1:0];

  always_comb begin
    if (region == REGION_W'(0)) begin
      if (strobe.remapped)       target = TGT_SRAM;
      else if (strobe.bootFlash) target = TGT_FLASH;
      else                       target = TGT_ROM;
    end else if (region == REGION_W'(1)) begin
      target = TGT_FLASH;
    end else if (region == REGION_W'(2)) begin
      target = TGT_SRAM;
    end else if (region == REGION_W'(3)) begin
      target = TGT_ROM;
    end else begin
      target = TGT_ABORT;
    end
  end

  always_comb begin
    case (target)
      TGT_FLASH: offMask = FLASH_MASK;
      TGT_SRAM:  offMask = SRAM_MASK;
      TGT_ROM:   offMask = ROM_MASK;
      default:   offMask = '0;
    endcase
  end

  assign csFlash     = accValid && (target == TGT_FLASH);
  assign csSram      = accValid && (target == TGT_SRAM);
  assign csRom       = accValid && (target == TGT_ROM);
  assign abort       = accValid && (target == TGT_ABORT);
  assign localOffset = accValid ? (rawOff & offMask) : '0;

  generate
    if (FLASH_KB == 512) begin : g_dual_plane
      assign flashPlane = csFlash & localOffset[PLANE_BIT];
    end else begin : g_single_plane
      assign flashPlane = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import brd_pkg::*;
#(
  parameter int ADDR_W      = 28,
  parameter int REGION_BITS = 20,
  parameter int SRAM_KB     = 128,
  parameter int FLASH_KB    = 512,
  parameter int ROM_KB      = 32
) (
  input  logic                   clk,
  input  logic                   porRst_n,
  input  logic                   softRst_n,
  input  logic                   accValid,
  input  logic [ADDR_W-1:0]      accAddr,
  input  logic                   cmdRemap,
  input  logic                   cmdSetBoot,
  input  logic                   cmdClearBoot,
  input  logic                   eraseIn,
  output logic                   csFlash,
  output logic                   csSram,
  output logic                   csRom,
  output logic                   abort,
  output logic [REGION_BITS-1:0] localOffset,
  output logic                   flashPlane
);

  ctrl_strobe_t strobe;

  brd_ctrl u_ctrl (
    .clk          (clk),
    .porRst_n     (porRst_n),
    .softRst_n    (softRst_n),
    .cmdRemap     (cmdRemap),
    .cmdSetBoot   (cmdSetBoot),
    .cmdClearBoot (cmdClearBoot),
    .eraseIn      (eraseIn),
    .strobe       (strobe)
  );

  brd_datapath #(
    .ADDR_W      (ADDR_W),
    .REGION_BITS (REGION_BITS),
    .SRAM_KB     (SRAM_KB),
    .FLASH_KB    (FLASH_KB),
    .ROM_KB      (ROM_KB)
  ) u_dp (
    .accValid    (accValid),
    .accAddr     (accAddr),
    .strobe      (strobe),
    .csFlash     (csFlash),
    .csSram      (csSram),
    .csRom       (csRom),
    .abort       (abort),
    .localOffset (localOffset),
    .flashPlane  (flashPlane)
  );

endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
  parameter int ADDR_W      = 28,
  parameter int REGION_BITS = 20
) (
  input logic              clk,
  input logic              porRst_n,
  input logic              softRst_n,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic              eraseIn,
  input logic              csFlash,
  input logic              csSram,
  input logic              csRom,
  input logic              abort,
  input logic              flashPlane,
  input logic              remapped,
  input logic              bootFlash
);

  logic [ADDR_W-REGION_BITS-1:0] region;
  assign region = accAddr[ADDR_W-1:REGION_BITS];

  assert_exclusive_R1: assert property (@(posedge clk) disable iff (!porRst_n)
    $onehot0({csFlash, csSram, csRom, abort}));

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!porRst_n)
    accValid |-> $countones({csFlash, csSram, csRom, abort}) == 1);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!porRst_n)
    !accValid |-> !(csFlash || csSram || csRom || abort || flashPlane));

  assert_undef_abort_R4: assert property (@(posedge clk) disable iff (!porRst_n)
    (accValid && region >= 4) |-> abort);

  assert_remap_sticky_R3: assert property (@(posedge clk) disable iff (!porRst_n || !softRst_n)
    remapped |=> remapped);

  assert_remap_alias_R3: assert property (@(posedge clk) disable iff (!porRst_n)
    (accValid && region == 0 && remapped) |-> csSram);

  assert_erase_clears_R8: assert property (@(posedge clk) disable iff (!porRst_n)
    eraseIn |=> !bootFlash);

  assert_plane_only_flash_R6: assert property (@(posedge clk) disable iff (!porRst_n)
    !csFlash |-> !flashPlane);

endmodule

bind boot_remap_decoder brd_checker #(
  .ADDR_W      (ADDR_W),
  .REGION_BITS (REGION_BITS)
) u_checker (
  .clk        (clk),
  .porRst_n   (porRst_n),
  .softRst_n  (softRst_n),
  .accValid   (accValid),
  .accAddr    (accAddr),
  .eraseIn    (eraseIn),
  .csFlash    (csFlash),
  .csSram     (csSram),
  .csRom      (csRom),
  .abort      (abort),
  .flashPlane (flashPlane),
  .remapped   (strobe.remapped),
  .bootFlash  (strobe.bootFlash)
);

// File: tb/tb_boot_remap_decoder.sv
`timescale 1ns/1ps
module tb_boot_remap_decoder;

  localparam int ADDR_W   = 28;
  localparam int OFF_W    = 20;
  localparam int SRAM_KB  = 128;
  localparam int FLASH_KB = 512;
  localparam int ROM_KB   = 32;

  logic clk = 1'b0;
  logic porRst_n = 1'b0, softRst_n = 1'b1;
  logic accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic cmdRemap = 1'b0, cmdSetBoot = 1'b0, cmdClearBoot = 1'b0, eraseIn = 1'b0;
  logic csFlash, csSram, csRom, abort, flashPlane;
  logic [OFF_W-1:0] localOffset;

  always #2 clk = ~clk;  // 250 MHz

  boot_remap_decoder dut (
    .clk(clk), .porRst_n(porRst_n), .softRst_n(softRst_n),
    .accValid(accValid), .accAddr(accAddr),
    .cmdRemap(cmdRemap), .cmdSetBoot(cmdSetBoot), .cmdClearBoot(cmdClearBoot),
    .eraseIn(eraseIn),
    .csFlash(csFlash), .csSram(csSram), .csRom(csRom), .abort(abort),
    .localOffset(localOffset), .flashPlane(flashPlane)
  );

  typedef struct packed {
    logic [3:0]       sel;   // {csFlash, csSram, csRom, abort}
    logic [OFF_W-1:0] off;
    logic             plane;
  } item_t;

  item_t expQ[$];
  string tagQ[$];
  event  monEv;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Bench-side model of the control state
  logic mRemap = 1'b0;
  logic mBoot  = 1'b0;

  function automatic item_t predict(logic v, logic [ADDR_W-1:0] a);
    item_t it;
    int reg_i;
    int size;
    it = '0;
    if (!v) return it;
    reg_i = int'(a[ADDR_W-1:OFF_W]);
    size = 0;
    if (reg_i == 0) begin
      if (mRemap)     begin it.sel = 4'b0100; size = SRAM_KB;  end
      else if (mBoot) begin it.sel = 4'b1000; size = FLASH_KB; end
      else            begin it.sel = 4'b0010; size = ROM_KB;   end
    end else if (reg_i == 1) begin it.sel = 4'b1000; size = FLASH_KB; end
    else if (reg_i == 2)     begin it.sel = 4'b0100; size = SRAM_KB;  end
    else if (reg_i == 3)     begin it.sel = 4'b0010; size = ROM_KB;   end
    else                     begin it.sel = 4'b0001; size = 0;        end
    if (size != 0) it.off = OFF_W'(int'(a[OFF_W-1:0]) % (size * 1024));
    it.plane = (FLASH_KB == 512) && it.sel[3] && it.off[18];
    return it;
  endfunction

  task automatic access(input logic v, input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    accValid = v;
    accAddr  = a;
    #1;
    expQ.push_back(predict(v, a));
    tagQ.push_back(tag);
    ->monEv;
  endtask

  // Pulse a command for one clock edge; model updates afterwards
  task automatic command(input logic rm, input logic sb, input logic cb, input logic er);
    @(negedge clk);
    cmdRemap = rm; cmdSetBoot = sb; cmdClearBoot = cb; eraseIn = er;
    @(negedge clk);
    cmdRemap = 0; cmdSetBoot = 0; cmdClearBoot = 0; eraseIn = 0;
    if (rm) mRemap = 1'b1;
    if (er || cb) mBoot = 1'b0;
    else if (sb)  mBoot = 1'b1;
  endtask

  // Monitor: pops and compares as results appear
  initial begin
    forever begin
      @(monEv);
      while (expQ.size() > 0) begin
        item_t e, g;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        g = '{sel: {csFlash, csSram, csRom, abort}, off: localOffset, plane: flashPlane};
        checks++;
        if (g !== e) begin
          errors++;
          $display("FAIL %s: got sel=%b off=%h plane=%b expected sel=%b off=%h plane=%b",
                   t, g.sel, g.off, g.plane, e.sel, e.off, e.plane);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    porRst_n = 1'b1;
    // Reset state: region 0 boots from ROM (R2, R9)
    access(1, 28'h000_0010, "R9 reset state region0=ROM");
    access(0, 28'h010_0000, "R10 idle outputs zero");
    // Fixed regions (R1)
    access(1, 28'h010_0004, "R1 flash region");
    access(1, 28'h020_0008, "R1 sram region");
    access(1, 28'h030_000C, "R1 rom region");
    // Undefined space (R4)
    access(1, 28'h040_0000, "R4 first undefined");
    access(1, 28'hFFF_FFFF, "R4 top undefined");
    // Wrap (R5): SRAM 128KB, ROM 32KB, Flash 512KB
    access(1, 28'h022_0004, "R5 sram wrap");
    access(1, 28'h03F_8010, "R5 rom wrap");
    access(1, 28'h01F_FFFF, "R5 flash wrap");
    // Plane select (R6)
    access(1, 28'h014_0000, "R6 flash plane 1");
    access(1, 28'h013_FFFC, "R6 flash plane 0");
    access(1, 28'h024_0000, "R6 plane low on sram");
    // Boot bit set (R7, R2)
    command(0, 1, 0, 0);
    access(1, 28'h004_0000, "R7 set boot region0=Flash R2");
    // Soft reset keeps boot bit (R9)
    @(negedge clk); softRst_n = 1'b0;
    @(negedge clk); softRst_n = 1'b1; mRemap = 1'b0;
    access(1, 28'h004_0000, "R9 soft reset keeps boot");
    // Erase clears, even with set (R8)
    command(0, 1, 0, 1);
    access(1, 28'h000_0100, "R8 erase over set");
    // Set and clear together: clear wins (R7)
    command(0, 1, 0, 0);
    command(0, 1, 1, 0);
    access(1, 28'h000_0100, "R7 clear beats set");
    // Remap (R3)
    command(0, 1, 0, 0);
    access(1, 28'h000_0200, "R2 before remap flash");
    command(1, 0, 0, 0);
    access(1, 28'h002_0204, "R3 remap region0=SRAM wrap");
    command(0, 0, 1, 0);
    access(1, 28'h000_0200, "R3 remap independent of boot");
    command(0, 1, 0, 0);
    access(1, 28'h000_0200, "R3 remap sticky");
    // Soft reset drops remap (R9)
    @(negedge clk); softRst_n = 1'b0;
    @(negedge clk); softRst_n = 1'b1; mRemap = 1'b0;
    access(1, 28'h000_0200, "R9 soft reset drops remap");
    // Power-on reset clears the boot bit too (R9)
    command(1, 0, 0, 0);
    @(negedge clk); porRst_n = 1'b0;
    @(negedge clk); porRst_n = 1'b1; mRemap = 1'b0; mBoot = 1'b0;
    access(1, 28'h000_0200, "R9 power-on clears boot");
    access(0, 28'h000_0200, "R10 idle after traffic");
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule